// File: doc/BRIEF.md
# Exception Vector and Cause Generator

This block sits beside a processor's control registers. When the pipeline flags an exception, it picks the handler entry address and captures the processor state that the handler needs. It saves the resume PC, records whether the faulting instruction sat in a branch delay slot, writes the exception code and coprocessor number, and produces the updated exception-level, error-level and boot-vector status bits.

The handler address depends on several inputs: whether the boot vectors are selected, whether an exception is already being handled, whether a TLB fault is a refill, whether the exception is a cache error, and, for interrupts, whether vectored interrupts are on. With vectored interrupts on, the highest-numbered interrupt line that is both pending and enabled selects one of a set of evenly spaced entry points.

Non-maskable interrupts and soft resets take a separate path. They save into the error PC and jump to the fixed boot address.

Every update is registered. One clock edge after `exc_valid` is sampled high, the new PC, all captured state and the updated status bits appear together with a one-cycle `redirect` strobe. The captured registers then hold their values until the next exception.

Top module: `exc_vector_gen`

## Requirements
- R1: After reset, `redirect`, `redirect_pc`, `epc`, `error_epc`, `cause_bd`, `cause_code`, `cause_cop`, `exl_o`, `erl_o` and `bev_o` are all zero.
- R2: For ordinary exceptions, the handler address is a base plus an offset. The base is 0xBFC00200 when `status_bev` is 1. Otherwise it is `ebase` with bits 9:0 cleared. The offset is 0x180 unless a later requirement gives another value.
- R3: An interrupt is `exc_kind` 0. With `vec_irq_en` 0, or with `status_bev` 1, or with `vec_spacing` 0, its offset is 0x200 when `vec_irq_en` is 1 and 0x180 when it is 0. Otherwise the offset is 0x200 + v*`vec_spacing`*32, where v is the index of the highest set bit of `irq_pending` AND `irq_mask`, or 0 if none is set.
- R4: A TLB load fault (`exc_kind` 2) or TLB store fault (`exc_kind` 3) with `tlb_nomatch` 1 and `status_exl` 0 uses offset 0x000. With `status_exl` 1 it uses 0x180.
- R5: A cache error (`exc_kind` 30) uses offset 0x100 when `status_bev` is 1 and 0x20000100 when it is 0. It is otherwise handled as an ordinary exception.
- R6: For ordinary exceptions, `epc` and `cause_bd` are updated only when `status_exl` is 0. `epc` takes `cur_pc`, or `cur_pc`-4 when `in_delay_slot` is 1. `cause_bd` takes `in_delay_slot`. `exl_o` becomes 1, while `erl_o` and `bev_o` copy `status_erl` and `status_bev`.
- R7: For ordinary exceptions, `cause_code` takes `exc_kind`. The code values are: interrupt 0, TLB modify 1, TLB load 2, TLB store 3, address error on load 4 and on store 5, bus error on fetch 6 and on data 7, syscall 8, break 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, floating point 15, read-inhibit 19, execute-inhibit 20, machine check 24, cache error 30. `cause_cop` takes `cop_num` only for code 11 and is otherwise unchanged.
- R8: A non-maskable interrupt (`exc_kind` 28) or a soft reset (`exc_kind` 29) jumps to 0xBFC00000. It writes the resume PC (as in R6) to `error_epc` and sets `erl_o` and `bev_o` to 1. `exl_o` copies `status_exl`. `epc` and `cause_code` are unchanged. `cause_bd` is cleared when `status_exl` is 0.
- R9: `redirect` is high for exactly the cycle after each cycle in which `exc_valid` is sampled high. The captured registers do not change when no exception was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | An exception is taken this cycle |
| exc_kind | input | 5 | Exception kind (code values of R7, plus 28 and 29) |
| tlb_nomatch | input | 1 | TLB fault had no matching entry |
| cop_num | input | 2 | Coprocessor number for coprocessor-unusable |
| cur_pc | input | 32 | PC of the faulting instruction |
| in_delay_slot | input | 1 | Faulting instruction is in a delay slot |
| status_bev | input | 1 | Boot exception vectors selected |
| status_exl | input | 1 | Exception level currently set |
| status_erl | input | 1 | Error level currently set |
| vec_irq_en | input | 1 | Vectored interrupts enabled |
| ebase | input | 32 | Exception base register |
| vec_spacing | input | 5 | Vectored interrupt spacing in 32-byte units |
| irq_pending | input | 8 | Pending interrupt lines |
| irq_mask | input | 8 | Interrupt enable mask |
| redirect | output | 1 | One-cycle strobe: fetch from `redirect_pc` |
| redirect_pc | output | 32 | Handler entry address |
| epc | output | 32 | Saved exception PC |
| error_epc | output | 32 | Saved error PC |
| cause_bd | output | 1 | Branch-delay flag |
| cause_code | output | 5 | Exception code field |
| cause_cop | output | 2 | Coprocessor number field |
| exl_o | output | 1 | Updated exception-level bit |
| erl_o | output | 1 | Updated error-level bit |
| bev_o | output | 1 | Updated boot-vector bit |

## Verification
A nested exception is one that arrives while the exception level is already set. In that case the offset choice and the capture logic act in the same cycle and must agree. A TLB refill must fall back to the general offset, while the saved PC and delay flag stay frozen and the code still updates. The bench provokes this by sweeping every ordinary kind across both settings of the exception level, delay slot, refill flag and boot-vector bit. Each time it compares the handler address, the saved PC, the flag and the code with values it tracks itself.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

    localparam int XLEN = 32;
    localparam int CODE_W = 5;

    localparam logic [CODE_W-1:0] K_INT    = 5'd0;
    localparam logic [CODE_W-1:0] K_TLBL   = 5'd2;
    localparam logic [CODE_W-1:0] K_TLBS   = 5'd3;
    localparam logic [CODE_W-1:0] K_COPU   = 5'd11;
    localparam logic [CODE_W-1:0] K_NMI    = 5'd28;
    localparam logic [CODE_W-1:0] K_SRST   = 5'd29;
    localparam logic [CODE_W-1:0] K_CACHE  = 5'd30;

    localparam logic [XLEN-1:0] BOOT_RESET_PC = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] BOOT_EXC_BASE = 32'hBFC0_0200;
    localparam logic [XLEN-1:0] OFS_GENERAL   = 32'h0000_0180;
    localparam logic [XLEN-1:0] OFS_REFILL    = 32'h0000_0000;
    localparam logic [XLEN-1:0] OFS_IRQ       = 32'h0000_0200;
    localparam logic [XLEN-1:0] OFS_CERR_BOOT = 32'h0000_0100;
    localparam logic [XLEN-1:0] OFS_CERR_NORM = 32'h2000_0100;
    localparam logic [XLEN-1:0] BASE_LOW_MASK = 32'h0000_03FF;

    typedef struct packed {
        logic            redirect;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] err_epc;
        logic            bd;
        logic [CODE_W-1:0] code;
        logic [1:0]      cop;
        logic            exl;
        logic            erl;
        logic            bev;
    } exc_state_t;

endpackage

// File: rtl/exc_irq_prio.sv
module exc_irq_prio #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    logic [IDX_W-1:0] chain [N+1];

    assign chain[0] = '0;

    for (genvar g = 0; g < N; g++) begin : g_stage
        assign chain[g+1] = req[g] ? IDX_W'(g) : chain[g];
    end

    assign idx = chain[N];
    assign any = |req;

    always_comb begin
        if (any) begin
            AST_PRIO_TOP: assert ((req >> idx) == N'(1))
                else $error("priority index is not the highest request"); // R3
        end
    end

endmodule

// File: rtl/exc_offset_calc.sv
module exc_offset_calc
    import exc_vec_pkg::*;
#(
    parameter int IDX_W   = 3,
    parameter int SPACE_W = 5
) (
    input  logic [CODE_W-1:0]  kind,
    input  logic               bev,
    input  logic               exl,
    input  logic               iv,
    input  logic               nomatch,
    input  logic [SPACE_W-1:0] spacing,
    input  logic [IDX_W-1:0]   vec,
    input  logic [XLEN-1:0]    ebase,
    output logic [XLEN-1:0]    handler_pc
);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] step;
    logic [XLEN-1:0] vec_off;

    always_comb begin
        step    = XLEN'(spacing) << 5;
        vec_off = XLEN'(vec) * step;
        base    = bev ? BOOT_EXC_BASE : (ebase & ~BASE_LOW_MASK);
        offset  = OFS_GENERAL;
        unique case (kind)
            K_INT: begin
                if (iv) begin
                    if (bev || (spacing == '0)) offset = OFS_IRQ;
                    else                        offset = OFS_IRQ + vec_off;
                end
            end
            K_TLBL, K_TLBS: begin
                if (nomatch && !exl) offset = OFS_REFILL;
            end
            K_CACHE: begin
                offset = bev ? OFS_CERR_BOOT : OFS_CERR_NORM;
            end
            default: offset = OFS_GENERAL;
        endcase
        handler_pc = base + offset;
    end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_vec_pkg::*;
#(
    parameter int IRQ_N   = 8,
    parameter int SPACE_W = 5,
    localparam int IDX_W  = (IRQ_N > 1) ? $clog2(IRQ_N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_valid,
    input  logic [4:0]         exc_kind,
    input  logic               tlb_nomatch,
    input  logic [1:0]         cop_num,
    input  logic [31:0]        cur_pc,
    input  logic               in_delay_slot,
    input  logic               status_bev,
    input  logic               status_exl,
    input  logic               status_erl,
    input  logic               vec_irq_en,
    input  logic [31:0]        ebase,
    input  logic [SPACE_W-1:0] vec_spacing,
    input  logic [IRQ_N-1:0]   irq_pending,
    input  logic [IRQ_N-1:0]   irq_mask,
    output logic               redirect,
    output logic [31:0]        redirect_pc,
    output logic [31:0]        epc,
    output logic [31:0]        error_epc,
    output logic               cause_bd,
    output logic [4:0]         cause_code,
    output logic [1:0]         cause_cop,
    output logic               exl_o,
    output logic               erl_o,
    output logic               bev_o
);

    exc_state_t st_d, st_q;

    logic [IRQ_N-1:0] irq_live;
    logic [IDX_W-1:0] irq_vec;
    logic             irq_any;
    logic [XLEN-1:0]  handler_pc;
    logic [XLEN-1:0]  resume_pc;
    logic             is_err_kind;

    assign irq_live = irq_pending & irq_mask;

    exc_irq_prio #(.N(IRQ_N), .IDX_W(IDX_W)) u_prio (
        .req (irq_live),
        .idx (irq_vec),
        .any (irq_any)
    );

    exc_offset_calc #(.IDX_W(IDX_W), .SPACE_W(SPACE_W)) u_ofs (
        .kind       (exc_kind),
        .bev        (status_bev),
        .exl        (status_exl),
        .iv         (vec_irq_en),
        .nomatch    (tlb_nomatch),
        .spacing    (vec_spacing),
        .vec        (irq_any ? irq_vec : '0),
        .ebase      (ebase),
        .handler_pc (handler_pc)
    );

    assign is_err_kind = (exc_kind == K_NMI) || (exc_kind == K_SRST);
    assign resume_pc   = in_delay_slot ? (cur_pc - 32'd4) : cur_pc;

    always_comb begin
        st_d          = st_q;
        st_d.redirect = 1'b0;
        if (exc_valid) begin
            st_d.redirect = 1'b1;
            if (is_err_kind) begin
                st_d.pc      = BOOT_RESET_PC;
                st_d.err_epc = resume_pc;
                st_d.erl     = 1'b1;
                st_d.bev     = 1'b1;
                st_d.exl     = status_exl;
                if (!status_exl) st_d.bd = 1'b0;
            end else begin
                st_d.pc  = handler_pc;
                st_d.erl = status_erl;
                st_d.bev = status_bev;
                st_d.exl = 1'b1;
                if (!status_exl) begin
                    st_d.epc = resume_pc;
                    st_d.bd  = in_delay_slot;
                end
                st_d.code = exc_kind;
                if (exc_kind == K_COPU) st_d.cop = cop_num;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign redirect    = st_q.redirect;
    assign redirect_pc = st_q.pc;
    assign epc         = st_q.epc;
    assign error_epc   = st_q.err_epc;
    assign cause_bd    = st_q.bd;
    assign cause_code  = st_q.code;
    assign cause_cop   = st_q.cop;
    assign exl_o       = st_q.exl;
    assign erl_o       = st_q.erl;
    assign bev_o       = st_q.bev;

    AST_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> $past(exc_valid)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(exc_valid) |-> ($stable(epc) && $stable(cause_code) && !redirect)); // R9

    AST_EPC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && $past(status_exl)) |-> $stable(epc)); // R6

    AST_EXL_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !$past(exc_kind == K_NMI || exc_kind == K_SRST)) |-> exl_o); // R6

    AST_ERR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && $past(exc_kind == K_NMI || exc_kind == K_SRST))
            |-> (redirect_pc == BOOT_RESET_PC && erl_o && bev_o && $stable(cause_code))); // R8

endmodule

// File: tb/exc_vector_gen_test.sv
module exc_vector_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_kind = '0;
    logic        tlb_nomatch = 1'b0;
    logic [1:0]  cop_num = '0;
    logic [31:0] cur_pc = '0;
    logic        in_delay_slot = 1'b0;
    logic        status_bev = 1'b0;
    logic        status_exl = 1'b0;
    logic        status_erl = 1'b0;
    logic        vec_irq_en = 1'b0;
    logic [31:0] ebase = '0;
    logic [4:0]  vec_spacing = '0;
    logic [7:0]  irq_pending = '0;
    logic [7:0]  irq_mask = '0;

    logic        redirect, cause_bd, exl_o, erl_o, bev_o;
    logic [31:0] redirect_pc, epc, error_epc;
    logic [4:0]  cause_code;
    logic [1:0]  cause_cop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_epc = '0, m_err = '0;
    logic        m_bd = 1'b0;
    logic [4:0]  m_code = '0;
    logic [1:0]  m_cop = '0;

    always #2.5 clk = ~clk;

    exc_vector_gen uut (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_kind(exc_kind),
        .tlb_nomatch(tlb_nomatch), .cop_num(cop_num), .cur_pc(cur_pc),
        .in_delay_slot(in_delay_slot), .status_bev(status_bev),
        .status_exl(status_exl), .status_erl(status_erl), .vec_irq_en(vec_irq_en),
        .ebase(ebase), .vec_spacing(vec_spacing), .irq_pending(irq_pending),
        .irq_mask(irq_mask), .redirect(redirect), .redirect_pc(redirect_pc),
        .epc(epc), .error_epc(error_epc), .cause_bd(cause_bd),
        .cause_code(cause_code), .cause_cop(cause_cop), .exl_o(exl_o),
        .erl_o(erl_o), .bev_o(bev_o)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (ok !== 1'b1) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic is_err();
        return (exc_kind == 5'd28) || (exc_kind == 5'd29);
    endfunction

    function automatic string pc_tag();
        if (is_err()) return "R8";
        if (exc_kind == 5'd0) return "R3";
        if (exc_kind == 5'd2 || exc_kind == 5'd3) return "R4";
        if (exc_kind == 5'd30) return "R5";
        return "R2";
    endfunction

    function automatic logic [31:0] model_pc();
        logic [31:0] base, ofs;
        logic [7:0]  live;
        int          v;
        if (is_err()) return 32'hBFC0_0000;
        base = status_bev ? 32'hBFC0_0200 : (ebase & ~32'h3FF);
        ofs  = 32'h180;
        if ((exc_kind == 5'd2 || exc_kind == 5'd3) && tlb_nomatch && !status_exl)
            ofs = 32'h0;
        if (exc_kind == 5'd30) ofs = status_bev ? 32'h100 : 32'h2000_0100;
        if (exc_kind == 5'd0 && vec_irq_en) begin
            if (status_bev || vec_spacing == 0) ofs = 32'h200;
            else begin
                live = irq_pending & irq_mask;
                v = 0;
                for (int b = 0; b < 8; b++) if (live[b]) v = b;
                ofs = 32'h200 + 32'(v) * 32'(vec_spacing) * 32'd32;
            end
        end
        return base + ofs;
    endfunction

    task automatic fire();
        logic [31:0] resume, exp_pc;
        logic e_exl, e_erl, e_bev;
        string t;
        @(negedge clk);
        exc_valid = 1'b1;
        @(negedge clk);
        exc_valid = 1'b0;
        resume = in_delay_slot ? cur_pc - 32'd4 : cur_pc;
        exp_pc = model_pc();
        t = pc_tag();
        if (is_err()) begin
            m_err = resume;
            if (!status_exl) m_bd = 1'b0;
            e_exl = status_exl; e_erl = 1'b1; e_bev = 1'b1;
        end else begin
            if (!status_exl) begin m_epc = resume; m_bd = in_delay_slot; end
            m_code = exc_kind;
            if (exc_kind == 5'd11) m_cop = cop_num;
            e_exl = 1'b1; e_erl = status_erl; e_bev = status_bev;
        end
        chk(redirect == 1'b1, "R9 strobe", 32'(redirect), 32'd1);
        chk(redirect_pc == exp_pc, t, redirect_pc, exp_pc);
        chk(epc == m_epc, is_err() ? "R8 epc" : "R6 epc", epc, m_epc);
        chk(error_epc == m_err, "R8 error_epc", error_epc, m_err);
        chk(cause_bd == m_bd, is_err() ? "R8 bd" : "R6 bd", 32'(cause_bd), 32'(m_bd));
        chk(cause_code == m_code, "R7 code", 32'(cause_code), 32'(m_code));
        chk(cause_cop == m_cop, "R7 cop", 32'(cause_cop), 32'(m_cop));
        chk({exl_o, erl_o, bev_o} == {e_exl, e_erl, e_bev}, is_err() ? "R8 status" : "R6 status",
            32'({exl_o, erl_o, bev_o}), 32'({e_exl, e_erl, e_bev}));
        @(negedge clk);
        chk(redirect == 1'b0, "R9 single", 32'(redirect), 32'd0);
        chk(epc == m_epc && cause_code == m_code, "R9 hold", epc, m_epc);
    endtask

    int kl[18] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 15, 19, 20, 24, 30};
    int sp[6]  = '{0, 1, 2, 4, 8, 31};

    initial begin
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(redirect == 1'b0, "R1 redirect", 32'(redirect), 0);
        chk(redirect_pc == 0, "R1 pc", redirect_pc, 0);
        chk(epc == 0 && error_epc == 0, "R1 epc", epc | error_epc, 0);
        chk({cause_bd, cause_code, cause_cop} == 0, "R1 cause", 32'({cause_bd, cause_code, cause_cop}), 0);
        chk({exl_o, erl_o, bev_o} == 0, "R1 status", 32'({exl_o, erl_o, bev_o}), 0);

        // R2 R4 R5 R6 R7 ordinary kinds, including nested (EXL set)
        for (int k = 0; k < 18; k++) begin
            for (int c = 0; c < 16; c++) begin
                exc_kind      = 5'(kl[k]);
                status_bev    = c[0];
                status_exl    = c[1];
                in_delay_slot = c[2];
                tlb_nomatch   = c[3];
                status_erl    = c[0] ^ c[2];
                cop_num       = 2'(n);
                cur_pc        = 32'h0040_0000 + 32'(n) * 32'd20;
                ebase         = 32'h8000_0000 + 32'(n) * 32'h0001_2345;
                vec_irq_en    = 1'b0;
                fire();
                n++;
            end
        end

        // R3 vectored and non-vectored interrupts
        for (int iv = 0; iv < 2; iv++) begin
            for (int bv = 0; bv < 2; bv++) begin
                for (int s = 0; s < 6; s++) begin
                    for (int p = 0; p < 256; p += 17) begin
                        for (int m = 0; m < 2; m++) begin
                            exc_kind      = 5'd0;
                            vec_irq_en    = iv[0];
                            status_bev    = bv[0];
                            status_exl    = 1'(n % 3 == 0);
                            in_delay_slot = 1'(n % 5 == 0);
                            vec_spacing   = 5'(sp[s]);
                            irq_pending   = 8'(p);
                            irq_mask      = m[0] ? 8'h5A : 8'hFF;
                            cur_pc        = 32'h0080_0000 + 32'(n) * 32'd4;
                            ebase         = 32'h9000_0000 | 32'(n);
                            fire();
                            n++;
                        end
                    end
                end
            end
        end

        // R8 non-maskable interrupt and soft reset
        for (int k = 28; k < 30; k++) begin
            for (int c = 0; c < 8; c++) begin
                exc_kind      = 5'(k);
                status_exl    = c[0];
                in_delay_slot = c[1];
                status_bev    = c[2];
                status_erl    = 1'b0;
                cur_pc        = 32'h00C0_0000 + 32'(n) * 32'd8;
                fire();
                n++;
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: got %h expected %h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule